// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Register Bus

This block gathers a configurable number of level-sensitive interrupt lines, grouped into 32-line banks, and presents them to a processor as one interrupt request. Every line has a mask bit. Software never writes the mask directly. It writes ones to a per-bank clear register to enable lines and to a per-bank set register to disable them. A per-bank pending register shows which lines are both high and enabled.

When nothing is latched and some line is pending, the controller picks the lowest-numbered pending line. It freezes that number in an active-interrupt register and raises the processor request. Both stay unchanged until software writes the acknowledge bit in the control register. Software also writes this acknowledge when the latched line was masked or dropped while it was being serviced.

A configuration register holds an autoidle bit and starts a soft reset. The soft reset holds the whole block at its reset values for a fixed number of cycles, and a status bit shows when it has finished. A protection bit and two idle bits are stored and read back. A revision register reports a major and a minor version.

The register bus is a plain single-cycle port. A write takes effect at the clock edge where `bus_we` is high. A read is combinational from `bus_addr`. The bus has no handshake and no back-pressure, so every access completes in the cycle it is presented.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, the active register (0x40) reads 0, `cpu_irq` is low, and status (0x14) bit 0 reads 1.
- R2: Writing to the clear register of bank n (0x88 + 0x20·n) enables each line whose data bit is 1. Zero bits leave their mask bits unchanged.
- R3: Writing to the set register of bank n (0x8C + 0x20·n) disables each line whose data bit is 1. Zero bits leave their mask bits unchanged.
- R4: The mask register of bank n (0x84 + 0x20·n) reads the current mask, with bit i of bank n belonging to line 32·n + i.
- R5: The pending register of bank n (0x98 + 0x20·n) reads the bank's lines ANDed with the inverse of its mask. It reads 0 when no enabled line is high.
- R6: When no interrupt is latched and a line is pending at a clock edge, that edge latches the lowest-numbered pending line into bits 6:0 of 0x40 and raises `cpu_irq`.
- R7: While an interrupt is latched and no acknowledge is written, `cpu_irq` stays high and 0x40 keeps its value. This holds even if the line drops, is masked, or a lower-numbered line becomes pending.
- R8: A write to control (0x48) with data bit 0 set clears `cpu_irq` and the active register to 0 at that edge. A control write with bit 0 clear has no effect.
- R9: Writing 1 to bit 1 of config (0x10) starts a soft reset that lasts SRST_CYCLES cycles. During the soft reset, status bit 0 reads 0, config bit 1 reads 1, and register writes are ignored. Afterwards every register holds its R1 value.
- R10: Config bit 0 (autoidle), protection (0x4C) bit 0 and idle (0x50) bits 1:0 store the written value and read it back. All other bits of these registers read 0.
- R11: The revision register (0x00) reads the major version in bits 7:4 and the minor version in bits 3:0.
- R12: Write-only and unmapped addresses, including the clear and set registers, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt inputs |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with NUM_LINES = 128 and SRST_CYCLES = 4. The fourth bank (0xE4/0xE8/0xEC/0xF8) and line 127, the highest-numbered line, become reachable only in this configuration. The short soft-reset window lets the bench observe the busy period cycle by cycle and confirm that writes inside it are dropped.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int BANK_W = 32;

  localparam logic [7:0] OFS_REV     = 8'h00;
  localparam logic [7:0] OFS_SYSCFG  = 8'h10;
  localparam logic [7:0] OFS_SYSSTAT = 8'h14;
  localparam logic [7:0] OFS_ACTIVE  = 8'h40;
  localparam logic [7:0] OFS_CTRL    = 8'h48;
  localparam logic [7:0] OFS_PROT    = 8'h4C;
  localparam logic [7:0] OFS_IDLE    = 8'h50;

  // bank registers: addr[7:5] selects bank (4 + n), addr[4:0] selects the register
  localparam int         BANK_SEL0 = 4;
  localparam logic [4:0] BOFS_MASK = 5'h04;
  localparam logic [4:0] BOFS_CLR  = 5'h08;
  localparam logic [4:0] BOFS_SET  = 5'h0C;
  localparam logic [4:0] BOFS_PEND = 5'h18;
endpackage

// File: rtl/lic_mask_bank.sv
module lic_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         clr_we,
  input  logic         set_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lines,
  output logic [W-1:0] mask,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '1;
    else if (srst)   mask <= '1;
    else if (clr_we) mask <= mask & ~wdata;
    else if (set_we) mask <= mask | wdata;
  end

  assign pend = lines & ~mask;

  a_r2_clear_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !srst) |=> ((mask & $past(wdata)) == '0));
  a_r2_clear_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !srst) |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
  a_r3_set_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we && !srst) |=> ((mask & $past(wdata)) == $past(wdata)));
  a_r9_mask_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (mask == '1));
endmodule

// File: rtl/lic_prio_enc.sv
module lic_prio_enc #(
  parameter int N  = 96,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  always_comb begin
    if (any) begin
      a_r6_lowest_pending: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/lic_cfg_regs.sv
module lic_cfg_regs #(
  parameter int SRST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       prot_we,
  input  logic       idle_we,
  input  logic [1:0] wdata,
  output logic       srst_active,
  output logic       rst_done,
  output logic       autoidle,
  output logic       prot_en,
  output logic [1:0] idle_bits
);
  localparam int CW = $clog2(SRST_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      autoidle  <= 1'b0;
      prot_en   <= 1'b0;
      idle_bits <= 2'b00;
    end else if (cnt != '0) begin
      cnt       <= cnt - 1'b1;
      autoidle  <= 1'b0;
      prot_en   <= 1'b0;
      idle_bits <= 2'b00;
    end else begin
      if (cfg_we) begin
        if (wdata[1]) begin
          cnt       <= CW'(SRST_CYCLES);
          autoidle  <= 1'b0;
          prot_en   <= 1'b0;
          idle_bits <= 2'b00;
        end else begin
          autoidle <= wdata[0];
        end
      end
      if (prot_we) prot_en   <= wdata[0];
      if (idle_we) idle_bits <= wdata;
    end
  end

  assign srst_active = (cnt != '0);
  assign rst_done    = (cnt == '0);

  a_r9_srst_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wdata[1] && !srst_active) |=> (srst_active && !autoidle && !prot_en));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_active && !cfg_we && !prot_we && !idle_we) |=> $stable({autoidle, prot_en, idle_bits}));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NUM_LINES   = 96,
  parameter int SRST_CYCLES = 4,
  parameter int REV_MAJOR   = 5,
  parameter int REV_MINOR   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [7:0]           bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 cpu_irq
);
  import lic_pkg::*;

  localparam int NUM_BANKS = NUM_LINES / BANK_W;
  localparam int IW        = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] mask_all, pend_all;
  logic                 srst_active, rst_done, autoidle, prot_en;
  logic [1:0]           idle_bits;
  logic                 any_pend;
  logic [IW-1:0]        sel_idx;
  logic                 act_valid;
  logic [IW-1:0]        act_num;
  logic                 ack_w;

  assign ack_w = bus_we && (bus_addr == OFS_CTRL) && bus_wdata[0];

  lic_cfg_regs #(.SRST_CYCLES(SRST_CYCLES)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (bus_we && bus_addr == OFS_SYSCFG),
    .prot_we    (bus_we && bus_addr == OFS_PROT),
    .idle_we    (bus_we && bus_addr == OFS_IDLE),
    .wdata      (bus_wdata[1:0]),
    .srst_active(srst_active),
    .rst_done   (rst_done),
    .autoidle   (autoidle),
    .prot_en    (prot_en),
    .idle_bits  (idle_bits)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_we && (bus_addr[7:5] == 3'(BANK_SEL0 + b));
    lic_mask_bank #(.W(BANK_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst_active),
      .clr_we(hit && bus_addr[4:0] == BOFS_CLR),
      .set_we(hit && bus_addr[4:0] == BOFS_SET),
      .wdata (bus_wdata),
      .lines (irq_lines[b*BANK_W +: BANK_W]),
      .mask  (mask_all[b*BANK_W +: BANK_W]),
      .pend  (pend_all[b*BANK_W +: BANK_W])
    );
  end

  lic_prio_enc #(.N(NUM_LINES), .IW(IW)) u_prio (
    .req(pend_all),
    .any(any_pend),
    .idx(sel_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_num   <= '0;
    end else if (srst_active || ack_w) begin
      act_valid <= 1'b0;
      act_num   <= '0;
    end else if (!act_valid && any_pend) begin
      act_valid <= 1'b1;
      act_num   <= sel_idx;
    end
  end

  assign cpu_irq = act_valid;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_REV:     bus_rdata = {24'b0, 4'(REV_MAJOR), 4'(REV_MINOR)};
      OFS_SYSCFG:  bus_rdata = {30'b0, srst_active, autoidle};
      OFS_SYSSTAT: bus_rdata = {31'b0, rst_done};
      OFS_ACTIVE:  bus_rdata = 32'(act_num);
      OFS_PROT:    bus_rdata = {31'b0, prot_en};
      OFS_IDLE:    bus_rdata = {30'b0, idle_bits};
      default:     bus_rdata = '0;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr[7:5] == 3'(BANK_SEL0 + b)) begin
        if (bus_addr[4:0] == BOFS_MASK)      bus_rdata = mask_all[b*BANK_W +: BANK_W];
        else if (bus_addr[4:0] == BOFS_PEND) bus_rdata = pend_all[b*BANK_W +: BANK_W];
      end
    end
  end

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_active && !ack_w && !act_valid && any_pend) |=> (cpu_irq && act_num == $past(sel_idx)));
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_active && !ack_w && act_valid) |=> (cpu_irq && $stable(act_num)));
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_w |=> (!cpu_irq && act_num == '0));
  a_r9_active_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    srst_active |=> !cpu_irq);
endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
  localparam int NL = 128;
  localparam int SR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] t_lines = '0;
  logic [7:0]    t_addr = '0;
  logic          t_we = 1'b0;
  logic [31:0]   t_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          cpu_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lvl_irq_ctrl #(.NUM_LINES(NL), .SRST_CYCLES(SR), .REV_MAJOR(5), .REV_MINOR(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(t_lines), .bus_addr(t_addr),
    .bus_we(t_we), .bus_wdata(t_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  // behavioural reference model
  logic [NL-1:0] m_mask = '1;
  logic [NL-1:0] m_pend;
  bit            m_valid = 0;
  int            m_num = 0;
  int            m_cnt = 0;
  bit            m_auto = 0, m_prot = 0;
  logic [1:0]    m_idle = 2'b00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '1; m_valid = 0; m_num = 0; m_cnt = 0; m_auto = 0; m_prot = 0; m_idle = 0;
    end else if (m_cnt > 0) begin
      m_cnt--; m_mask = '1; m_valid = 0; m_num = 0; m_auto = 0; m_prot = 0; m_idle = 0;
    end else begin
      m_pend = t_lines & ~m_mask;
      if (t_we && t_addr == 8'h48 && t_wdata[0]) begin
        m_valid = 0; m_num = 0;
      end else if (!m_valid && m_pend != '0) begin
        for (int i = NL - 1; i >= 0; i--) if (m_pend[i]) m_num = i;
        m_valid = 1;
      end
      if (t_we) begin
        if (t_addr == 8'h10) begin
          if (t_wdata[1]) begin m_cnt = SR; m_auto = 0; m_prot = 0; m_idle = 0; end
          else m_auto = t_wdata[0];
        end
        if (t_addr == 8'h4C) m_prot = t_wdata[0];
        if (t_addr == 8'h50) m_idle = t_wdata[1:0];
        if (t_addr >= 8'h80) begin
          int b;
          b = int'(t_addr[7:5]) - 4;
          if (t_addr[4:0] == 5'h08) m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~t_wdata;
          if (t_addr[4:0] == 5'h0C) m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | t_wdata;
        end
      end
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [NL-1:0] p;
    p = t_lines & ~m_mask;
    case (a)
      8'h00: return 32'h51;
      8'h10: return {30'b0, m_cnt > 0, m_auto};
      8'h14: return {31'b0, m_cnt == 0};
      8'h40: return 32'(m_num);
      8'h4C: return {31'b0, m_prot};
      8'h50: return {30'b0, m_idle};
      default: ;
    endcase
    if (a >= 8'h80 && a[4:0] == 5'h04) return m_mask[(int'(a[7:5]) - 4)*32 +: 32];
    if (a >= 8'h80 && a[4:0] == 5'h18) return p[(int'(a[7:5]) - 4)*32 +: 32];
    return 32'h0;
  endfunction

  function automatic string req_of(logic [7:0] a);
    if (a == 8'h00) return "R11";
    if (a == 8'h10 || a == 8'h4C || a == 8'h50) return "R10";
    if (a == 8'h14) return "R9";
    if (a == 8'h40) return "R6";
    if (a >= 8'h80 && a[4:0] == 5'h04) return "R4";
    if (a >= 8'h80 && a[4:0] == 5'h18) return "R5";
    return "R12";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: compare the model with the outputs, then drive new inputs
  task automatic cyc(logic [7:0] a, logic we, logic [31:0] d);
    @(negedge clk);
    if (rst_n) begin
      check("R7 cpu_irq vs model", {31'b0, cpu_irq}, {31'b0, m_valid});
      check({req_of(t_addr), " rdata vs model"}, bus_rdata, model_read(t_addr));
    end
    t_addr = a; t_we = we; t_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(8'h00, 1'b0, 32'h0);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    cyc(a, 1'b0, 32'h0);
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(a, 1'b1, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(8'h84, 32'hFFFF_FFFF, "R1 mask bank0 after reset");
    rd(8'hE4, 32'hFFFF_FFFF, "R1 mask bank3 after reset");
    rd(8'h40, 32'h0, "R1 active after reset");
    rd(8'h14, 32'h1, "R1 status done after reset");
    check("R1 cpu_irq after reset", {31'b0, cpu_irq}, 32'h0);
    rd(8'h00, 32'h51, "R11 revision");

    // masked lines are not pending
    t_lines[40] = 1'b1; t_lines[70] = 1'b1;
    rd(8'hB8, 32'h0, "R5 masked bank1 pending");
    idle(2);
    check("R5 no irq while masked", {31'b0, cpu_irq}, 32'h0);

    // enable line 40
    wr(8'hA8, 32'h0000_0100);
    rd(8'hA4, 32'hFFFF_FEFF, "R2 clear enables line 40");
    idle(2);
    rd(8'h40, 32'd40, "R6 line 40 latched");
    rd(8'hB8, 32'h0000_0100, "R5 bank1 pending");
    check("R6 cpu_irq raised", {31'b0, cpu_irq}, 32'h1);

    // frozen while active
    wr(8'hC8, 32'h0000_0040);
    t_lines[40] = 1'b0;
    idle(3);
    rd(8'h40, 32'd40, "R7 active frozen after drop");
    check("R7 cpu_irq held", {31'b0, cpu_irq}, 32'h1);

    // control write without bit 0 does nothing
    wr(8'h48, 32'h0000_0002);
    idle(2);
    rd(8'h40, 32'd40, "R8 non-ack write ignored");

    // acknowledge: next pending (70) latched
    wr(8'h48, 32'h1);
    idle(2);
    rd(8'h40, 32'd70, "R8 next after ack");

    // lower line while 70 active, including bank3 line 127
    t_lines[5] = 1'b1; t_lines[127] = 1'b1;
    wr(8'h88, 32'h0000_0020);
    wr(8'hE8, 32'h8000_0000);
    idle(2);
    rd(8'h40, 32'd70, "R7 lower line does not preempt");
    rd(8'hF8, 32'h8000_0000, "R5 bank3 pending line 127");
    wr(8'h48, 32'h1);
    idle(2);
    rd(8'h40, 32'd5, "R6 lowest pending wins");

    // mask line 5 again, ack, expect 70
    wr(8'h8C, 32'h0000_0020);
    rd(8'h84, 32'hFFFF_FFFF, "R3 set masks line 5");
    wr(8'h48, 32'h1);
    idle(2);
    rd(8'h40, 32'd70, "R3 masked line skipped");
    t_lines[70] = 1'b0;
    wr(8'h48, 32'h1);
    idle(2);
    rd(8'h40, 32'd127, "R6 line 127 latched");

    // config registers
    wr(8'h10, 32'hFFFF_FFFD);
    rd(8'h10, 32'h1, "R10 autoidle readback");
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, 32'h1, "R10 protection readback");
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, 32'h3, "R10 idle readback");
    rd(8'h88, 32'h0, "R12 clear reg reads zero");
    rd(8'h48, 32'h0, "R12 control reads zero");
    rd(8'h20, 32'h0, "R12 unmapped reads zero");

    // soft reset
    wr(8'h10, 32'h2);
    rd(8'h14, 32'h0, "R9 busy status");
    rd(8'h10, 32'h2, "R9 busy config bit");
    wr(8'hA8, 32'hFFFF_FFFF);
    idle(SR + 1);
    rd(8'h14, 32'h1, "R9 done after soft reset");
    rd(8'hA4, 32'hFFFF_FFFF, "R9 write during reset ignored");
    rd(8'hE4, 32'hFFFF_FFFF, "R9 masks restored");
    rd(8'h40, 32'h0, "R9 active cleared");
    rd(8'h50, 32'h0, "R9 idle cleared");
    check("R9 cpu_irq cleared", {31'b0, cpu_irq}, 32'h0);
    idle(2);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule